// File: doc/BRIEF.md
# One-Time-Programmable Array Controller

This block sits behind a small memory-mapped register port and lets a host processor read rows of a one-time-programmable bit array and burn new bits into them. The host picks an operation code, a row address and, for programming, one or two data words. It then raises a start bit and polls a status word until the command-done flag appears. Data fetched by a read lands in one or two read-data registers. The array itself is a behavioural model: each bit starts at 0 after reset and can only ever move from 0 to 1.

Access is guarded in two ways. No command runs unless the access-grant bit in the mode register is set. Programming only changes the array after an unlock handshake has set a program-permitted flag. The handshake is four unlock commands, each carrying one key nibble in the first write-data word. The busy time of each command is fixed by parameters. For programming, the busy time also grows with the number of 1 bits in the row data, which mimics a fuse array that takes longer to burn more bits.

Top module: `otp_ctrl`

## Requirements
- R1: After reset every register reads 0, including status, address, both write-data words and both read-data words.
- R2: While bit 0 of the mode register (offset 0x00) is 0, writing 1 to the start register launches nothing. The status word stays 0 and the read-data registers do not change.
- R3: A command is launched by a bus write with data bit 0 = 1 to the start register (offset 0x08) while the start bit is 0. Command-done is status bit 1 at offset 0x0C, and status bit 0 shows busy. Command-done rises exactly N clock edges after the launching write. N is 4 for read (code 0x00). N is 8 plus the number of 1 bits in both write-data words for program (code 0x08). N is 2 for every other code.
- R4: Writing 0 to the start register clears command-done. Writing 1 while the start bit is already 1 launches nothing.
- R5: A finished read places the addressed row's first word at offset 0x10 and its second word at offset 0x5C.
- R6: A permitted program ORs the data into the addressed row. The first word is written at offset 0x2C and the second at offset 0x64. Bits that are already 1 stay 1.
- R7: Four unlock commands (code 0x02) whose first write-data word is 0xF, 0x4, 0x8 and 0xD, in that order, set status bit 2 (program permitted). Any other value restarts the key sequence.
- R8: A program command issued while status bit 2 is 0 still completes and sets command-done, but leaves the array unchanged.
- R9: A lock command (code 0x03) clears status bit 2.
- R10: The address register (offset 0x28) keeps only bits 15:0, so writing 0x12345 reads back 0x2345. The row used is the address modulo the row count (64 by default).
- R11: The command register (offset 0x04) keeps only bits 5:0, so writing 0xFF reads back 0x3F.
- R12: Register reads return data one clock after the request, flagged by the read-valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
Read data and the read-valid flag arrive one edge after the request. The command-done flag rises N edges after the launching start write, where N depends on the operation and, for programming, on the bit count of the data. A status poll therefore first shows done on the (N+1)-th back-to-back poll. The bench polls status every cycle right after the start write, counts the polls, and compares that count with N+1 computed from the operation and the data. All other register reads are paired with their expected values in a queue and compared by the monitor on the cycle the read-valid flag is set.

// File: rtl/otpc_pkg.sv
`timescale 1ns/1ps
package otpc_pkg;

  typedef enum logic [5:0] {
    OP_READ   = 6'h00,
    OP_UNLOCK = 6'h02,
    OP_LOCK   = 6'h03,
    OP_PROG   = 6'h08
  } otp_op_e;

  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_CMD   = 8'h04;
  localparam logic [7:0] OFS_START = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h0C;
  localparam logic [7:0] OFS_RDAT0 = 8'h10;
  localparam logic [7:0] OFS_ADDR  = 8'h28;
  localparam logic [7:0] OFS_WDAT0 = 8'h2C;
  localparam logic [7:0] OFS_RDAT1 = 8'h5C;
  localparam logic [7:0] OFS_WDAT1 = 8'h64;

  // Key nibble expected at each step of the unlock handshake (order matters)
  function automatic logic [3:0] unlock_key(input logic [1:0] step);
    case (step)
      2'd0:    return 4'hF;
      2'd1:    return 4'h4;
      2'd2:    return 4'h8;
      default: return 4'hD;
    endcase
  endfunction

  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += 32'(v[i]);
    return n;
  endfunction

  // Busy time in clock edges from launch to command-done
  function automatic int unsigned op_cycles(input logic [5:0] op,
                                            input logic [31:0] d0,
                                            input logic [31:0] d1,
                                            input int unsigned words,
                                            input int unsigned rd_cyc,
                                            input int unsigned ctl_cyc,
                                            input int unsigned pb,
                                            input int unsigned ppb);
    if (op == OP_READ) return rd_cyc;
    if (op == OP_PROG)
      return pb + ppb * (ones32(d0) + ((words > 1) ? ones32(d1) : 32'd0));
    return ctl_cyc;
  endfunction

endpackage

// File: rtl/otpc_array.sv
`timescale 1ns/1ps
module otpc_array #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned ROW_W = 64,
  localparam int unsigned ADDR_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] row,
  input  logic [ROW_W-1:0]  wdata,
  output logic [ROW_W-1:0]  rdata
);

  logic [ROW_W-1:0] mem_q [ROWS];
  logic [ROW_W-1:0] cur_row;

  assign cur_row = mem_q[row];
  assign rdata   = cur_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (we) begin
      mem_q[row] <= cur_row | wdata;
    end
  end

  // R6: no bit of a programmed row returns to 0
  assert_no_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((~mem_q[$past(row)] & $past(cur_row)) == '0));

endmodule

// File: rtl/otpc_regbank.sv
`timescale 1ns/1ps
module otpc_regbank
  import otpc_pkg::*;
#(
  parameter int unsigned ROW_WORDS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic        busy,
  input  logic        done,
  input  logic        prog_ok,
  input  logic        rd_load,
  input  logic [31:0] rd_word0,
  input  logic [31:0] rd_word1,
  output logic        mode_en,
  output logic [5:0]  cmd,
  output logic [15:0] row_addr,
  output logic [31:0] wdat0,
  output logic [31:0] wdat1,
  output logic        start_set,
  output logic        start_clr
);

  logic        wr_ev;
  logic        rd_ev;
  logic        mode_q;
  logic        start_q;
  logic [5:0]  cmd_q;
  logic [15:0] addr_q;
  logic [31:0] wd0_q;
  logic [31:0] rd0_q;
  logic [31:0] rd1;
  logic [31:0] rd_mux;

  assign wr_ev     = bus_valid & bus_write;
  assign rd_ev     = bus_valid & ~bus_write;
  assign start_set = wr_ev & (bus_addr == OFS_START) & bus_wdata[0] & ~start_q;
  assign start_clr = wr_ev & (bus_addr == OFS_START) & ~bus_wdata[0];

  assign mode_en  = mode_q;
  assign cmd      = cmd_q;
  assign row_addr = addr_q;
  assign wdat0    = wd0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      start_q <= 1'b0;
      cmd_q   <= '0;
      addr_q  <= '0;
      wd0_q   <= '0;
      rd0_q   <= '0;
    end else begin
      if (wr_ev) begin
        case (bus_addr)
          OFS_MODE:  mode_q  <= bus_wdata[0];
          OFS_CMD:   cmd_q   <= bus_wdata[5:0];
          OFS_START: start_q <= bus_wdata[0];
          OFS_ADDR:  addr_q  <= bus_wdata[15:0];
          OFS_WDAT0: wd0_q   <= bus_wdata;
          default:   ;
        endcase
      end
      if (rd_load) rd0_q <= rd_word0;
    end
  end

  generate
    if (ROW_WORDS > 1) begin : g_two_words
      logic [31:0] wd1_q;
      logic [31:0] rd1_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wd1_q <= '0;
          rd1_q <= '0;
        end else begin
          if (wr_ev && bus_addr == OFS_WDAT1) wd1_q <= bus_wdata;
          if (rd_load) rd1_q <= rd_word1;
        end
      end
      assign wdat1 = wd1_q;
      assign rd1   = rd1_q;
    end else begin : g_one_word
      logic unused_w1;
      assign unused_w1 = ^rd_word1;
      assign wdat1 = '0;
      assign rd1   = '0;
    end
  endgenerate

  always_comb begin
    case (bus_addr)
      OFS_MODE:  rd_mux = {31'b0, mode_q};
      OFS_CMD:   rd_mux = {26'b0, cmd_q};
      OFS_START: rd_mux = {31'b0, start_q};
      OFS_STAT:  rd_mux = {29'b0, prog_ok, done, busy};
      OFS_ADDR:  rd_mux = {16'b0, addr_q};
      OFS_WDAT0: rd_mux = wd0_q;
      OFS_WDAT1: rd_mux = wdat1;
      OFS_RDAT0: rd_mux = rd0_q;
      OFS_RDAT1: rd_mux = rd1;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_ev;
      if (rd_ev) bus_rdata <= rd_mux;
    end
  end

  // R12: read-valid follows a read request by exactly one edge
  assert_rvalid_lag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> bus_rvalid);
  // R4: a second start write while start is 1 is not a launch request
  assert_no_relaunch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !start_set);

endmodule

// File: rtl/otpc_seq.sv
`timescale 1ns/1ps
module otpc_seq
  import otpc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned ROW_WORDS    = 2,
  parameter int unsigned READ_CYC     = 4,
  parameter int unsigned CTRL_CYC     = 2,
  parameter int unsigned PROG_BASE    = 8,
  parameter int unsigned PROG_PER_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_set,
  input  logic              start_clr,
  input  logic              mode_en,
  input  logic [5:0]        cmd,
  input  logic [ADDR_W-1:0] row_in,
  input  logic [31:0]       wdat0,
  input  logic [31:0]       wdat1,
  output logic              busy,
  output logic              done,
  output logic              prog_ok,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_row,
  output logic [31:0]       arr_d0,
  output logic [31:0]       arr_d1,
  output logic              rd_load
);

  localparam int unsigned MAX_CYC =
    PROG_BASE + PROG_PER_BIT * 32 * ROW_WORDS + READ_CYC + CTRL_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  logic              busy_q;
  logic              done_q;
  logic              prog_ok_q;
  logic [1:0]        key_idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [5:0]        op_q;
  logic [ADDR_W-1:0] row_q;
  logic [31:0]       d0_q;
  logic [31:0]       d1_q;

  // Named internal events
  logic launch;
  logic finish;
  logic key_ok;

  assign launch = start_set & mode_en & ~busy_q & ~done_q;
  assign finish = busy_q & (cnt_q == '0);
  assign key_ok = (d0_q == {28'b0, unlock_key(key_idx_q)});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      prog_ok_q <= 1'b0;
      key_idx_q <= '0;
      cnt_q     <= '0;
      op_q      <= '0;
      row_q     <= '0;
      d0_q      <= '0;
      d1_q      <= '0;
    end else begin
      if (launch) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(op_cycles(cmd, wdat0, wdat1, ROW_WORDS, READ_CYC,
                                   CTRL_CYC, PROG_BASE, PROG_PER_BIT) - 1);
        op_q   <= cmd;
        row_q  <= row_in;
        d0_q   <= wdat0;
        d1_q   <= wdat1;
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end

      if (finish) done_q <= 1'b1;
      else if (start_clr) done_q <= 1'b0;

      if (finish && op_q == OP_LOCK) begin
        prog_ok_q <= 1'b0;
        key_idx_q <= '0;
      end else if (finish && op_q == OP_UNLOCK) begin
        if (!key_ok) begin
          key_idx_q <= '0;
        end else if (key_idx_q == 2'd3) begin
          prog_ok_q <= 1'b1;
          key_idx_q <= '0;
        end else begin
          key_idx_q <= key_idx_q + 2'd1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign prog_ok = prog_ok_q;
  assign arr_we  = finish & (op_q == OP_PROG) & prog_ok_q;
  assign rd_load = finish & (op_q == OP_READ);
  assign arr_row = row_q;
  assign arr_d0  = d0_q;
  assign arr_d1  = d1_q;

  // R3: done only ever rises out of a busy period
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q));
  // R4: writing start back to 0 drops done
  assert_done_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_clr && !finish) |=> !done_q);
  // R2: no command starts without the access grant
  assert_launch_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(mode_en));
  // R7: program permission appears only at the end of an unlock command
  assert_unlock_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_ok_q) |-> $past(finish && op_q == OP_UNLOCK));
  // R9: a finished lock leaves programming forbidden
  assert_lock_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && op_q == OP_LOCK) |=> !prog_ok_q);
  // R8: the array is never written while programming is forbidden
  assert_prog_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_ok_q |-> !arr_we);

endmodule

// File: rtl/otp_ctrl.sv
`timescale 1ns/1ps
module otp_ctrl #(
  parameter int unsigned ROWS         = 64,
  parameter int unsigned ROW_WORDS    = 2,
  parameter int unsigned READ_CYC     = 4,
  parameter int unsigned CTRL_CYC     = 2,
  parameter int unsigned PROG_BASE    = 8,
  parameter int unsigned PROG_PER_BIT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid
);

  localparam int unsigned ADDR_W = $clog2(ROWS);
  localparam int unsigned ROW_W  = 32 * ROW_WORDS;

  logic              mode_en;
  logic [5:0]        cmd;
  logic [15:0]       row_addr;
  logic [31:0]       wdat0;
  logic [31:0]       wdat1;
  logic              start_set;
  logic              start_clr;
  logic              busy;
  logic              done;
  logic              prog_ok;
  logic              rd_load;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_row;
  logic [31:0]       arr_d0;
  logic [31:0]       arr_d1;
  logic [ROW_W-1:0]  arr_wdata;
  logic [ROW_W-1:0]  arr_rdata;
  logic [31:0]       rd_word0;
  logic [31:0]       rd_word1;
  logic              unused_hi;

  assign unused_hi = ^row_addr[15:ADDR_W];

  generate
    if (ROW_WORDS > 1) begin : g_wide
      assign arr_wdata = {arr_d1, arr_d0};
      assign rd_word1  = arr_rdata[63:32];
    end else begin : g_narrow
      logic unused_d1;
      assign unused_d1 = ^arr_d1;
      assign arr_wdata = arr_d0;
      assign rd_word1  = '0;
    end
  endgenerate
  assign rd_word0 = arr_rdata[31:0];

  otpc_regbank #(.ROW_WORDS(ROW_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .busy(busy), .done(done), .prog_ok(prog_ok),
    .rd_load(rd_load), .rd_word0(rd_word0), .rd_word1(rd_word1),
    .mode_en(mode_en), .cmd(cmd), .row_addr(row_addr),
    .wdat0(wdat0), .wdat1(wdat1),
    .start_set(start_set), .start_clr(start_clr)
  );

  otpc_seq #(
    .ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS), .READ_CYC(READ_CYC),
    .CTRL_CYC(CTRL_CYC), .PROG_BASE(PROG_BASE), .PROG_PER_BIT(PROG_PER_BIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_set(start_set), .start_clr(start_clr), .mode_en(mode_en),
    .cmd(cmd), .row_in(row_addr[ADDR_W-1:0]), .wdat0(wdat0), .wdat1(wdat1),
    .busy(busy), .done(done), .prog_ok(prog_ok),
    .arr_we(arr_we), .arr_row(arr_row), .arr_d0(arr_d0), .arr_d1(arr_d1),
    .rd_load(rd_load)
  );

  otpc_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we(arr_we), .row(arr_row), .wdata(arr_wdata), .rdata(arr_rdata)
  );

endmodule

// File: tb/otp_ctrl_tb.sv
`timescale 1ns/1ps
module otp_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  otp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // Register offsets as stated in the requirements
  localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_START = 8'h08,
    A_STAT = 8'h0C, A_RD0 = 8'h10, A_ADDR = 8'h28, A_WD0 = 8'h2C,
    A_RD1 = 8'h5C, A_WD1 = 8'h64;

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pairs every valid read with the oldest queued expectation
  always @(negedge clk) begin
    if (rst_n && bus_rvalid && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(bus_rdata, e, t);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_raw(input logic [7:0] a, output logic [31:0] v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
    v = bus_rdata;
  endtask

  // Driver: pushes the expected value, the monitor compares it
  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e,
                        input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  function automatic int busy_edges(input logic [5:0] op,
                                    input logic [31:0] d0,
                                    input logic [31:0] d1);
    if (op == 6'h00) return 4;
    if (op == 6'h08) return 8 + $countones(d0) + $countones(d1);
    return 2;
  endfunction

  // R3: launch, poll status every cycle, expect done on poll N+1
  task automatic run_cmd(input logic [5:0] op, input logic [31:0] addr,
                         input logic [31:0] d0, input logic [31:0] d1,
                         input string tag);
    logic [31:0] v;
    int polls;
    wr(A_CMD, {26'b0, op});
    wr(A_ADDR, addr);
    wr(A_WD0, d0);
    wr(A_WD1, d1);
    wr(A_START, 32'h1);
    polls = 0;
    v = '0;
    while (polls < 300 && !v[1]) begin
      rd_raw(A_STAT, v);
      polls++;
    end
    check(polls, busy_edges(op, d0, d1) + 1, tag);
    wr(A_START, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd_exp(A_MODE, 32'h0, "R1 mode");
    rd_exp(A_STAT, 32'h0, "R1 status");
    rd_exp(A_ADDR, 32'h0, "R1 addr");
    rd_exp(A_WD1,  32'h0, "R1 wdata1");
    rd_exp(A_RD0,  32'h0, "R1 rdata0");
    rd_exp(A_RD1,  32'h0, "R1 rdata1");

    // R11, R10: field widths
    wr(A_CMD, 32'hFF);
    rd_exp(A_CMD, 32'h3F, "R11 cmd width");
    wr(A_ADDR, 32'h12345);
    rd_exp(A_ADDR, 32'h2345, "R10 addr width");

    // R2: no launch without access grant
    wr(A_CMD, 32'h0);
    wr(A_START, 32'h1);
    for (int i = 0; i < 12; i++) rd_raw(A_STAT, v);
    check(v, 32'h0, "R2 status stays idle");
    rd_exp(A_RD0, 32'h0, "R2 rdata untouched");
    wr(A_START, 32'h0);

    wr(A_MODE, 32'h1);
    // R3, R5: read a blank row
    run_cmd(6'h00, 32'd5, 32'h0, 32'h0, "R3 read timing");
    rd_exp(A_RD0, 32'h0, "R5 blank word0");
    rd_exp(A_STAT, 32'h0, "R4 done cleared by start=0");

    // R8: program while locked
    run_cmd(6'h08, 32'd5, 32'hA5, 32'h3, "R3 locked program timing");
    run_cmd(6'h00, 32'd5, 32'h0, 32'h0, "R3 read timing");
    rd_exp(A_RD0, 32'h0, "R8 locked word0 unchanged");
    rd_exp(A_RD1, 32'h0, "R8 locked word1 unchanged");

    // R7: wrong key restarts, correct order unlocks
    run_cmd(6'h02, 32'd0, 32'hF, 32'h0, "R3 unlock timing");
    run_cmd(6'h02, 32'd0, 32'h4, 32'h0, "R3 unlock timing");
    run_cmd(6'h02, 32'd0, 32'h9, 32'h0, "R3 unlock timing");
    run_cmd(6'h02, 32'd0, 32'h8, 32'h0, "R3 unlock timing");
    run_cmd(6'h02, 32'd0, 32'hD, 32'h0, "R3 unlock timing");
    rd_exp(A_STAT, 32'h0, "R7 broken sequence stays locked");
    run_cmd(6'h02, 32'd0, 32'hF, 32'h0, "R7 key1");
    run_cmd(6'h02, 32'd0, 32'h4, 32'h0, "R7 key2");
    run_cmd(6'h02, 32'd0, 32'h8, 32'h0, "R7 key3");
    run_cmd(6'h02, 32'd0, 32'hD, 32'h0, "R7 key4");
    rd_exp(A_STAT, 32'h4, "R7 program permitted");

    // R6: program, then OR in more bits
    run_cmd(6'h08, 32'd5, 32'hA5, 32'h3, "R3 program timing 6 bits");
    run_cmd(6'h00, 32'd5, 32'h0, 32'h0, "R3 read timing");
    rd_exp(A_RD0, 32'hA5, "R6 word0 programmed");
    rd_exp(A_RD1, 32'h3, "R6 word1 programmed");
    run_cmd(6'h08, 32'd5, 32'h5A, 32'h0, "R3 program timing 4 bits");
    // R10: row 69 wraps onto row 5
    run_cmd(6'h08, 32'd69, 32'h100, 32'h0, "R3 program timing 1 bit");
    run_cmd(6'h00, 32'd5, 32'h0, 32'h0, "R3 read timing");
    rd_exp(A_RD0, 32'h1FF, "R6 R10 OR and address wrap");
    rd_exp(A_RD1, 32'h3, "R6 word1 kept");

    // R4: start written 1 twice launches nothing the second time
    wr(A_START, 32'h1);
    for (int i = 0; i < 8; i++) rd_raw(A_STAT, v);
    check(v, 32'h6, "R4 done while start held");
    wr(A_ADDR, 32'd7);
    wr(A_START, 32'h1);
    for (int i = 0; i < 10; i++) rd_raw(A_STAT, v);
    rd_exp(A_RD0, 32'h1FF, "R4 repeated start ignored");
    wr(A_START, 32'h0);
    rd_exp(A_STAT, 32'h4, "R4 done cleared");

    // R9: lock, then program has no effect
    run_cmd(6'h03, 32'd0, 32'h0, 32'h0, "R3 lock timing");
    rd_exp(A_STAT, 32'h0, "R9 permission cleared");
    run_cmd(6'h08, 32'd6, 32'hF, 32'h0, "R3 program timing locked");
    run_cmd(6'h00, 32'd6, 32'h0, 32'h0, "R3 read timing");
    rd_exp(A_RD0, 32'h0, "R9 R8 row 6 unchanged");

    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R3: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule